// File: doc/BRIEF.md
# Repeated Signaling Codeword Transmitter

This block puts short bit-oriented signaling codewords onto a framer's data-link bit stream. The host loads a six-bit message as one framed byte into one of two message buffers. It sets a repetition count and arms the transmission. The block then sends the codeword the requested number of times. A codeword is eight ones followed by the framed byte, sent one bit per bit-request strobe. When the run is over, the block raises a sticky end-of-transfer flag. It then fills the link with idle flag characters (0x7E) or with a continuous run of ones (abort), whichever the host selects.

The two buffers let the host prepare the next message while the current one is still being sent. A status output names the buffer that is free for the next message. Arming a message makes it pending. A pending message takes over only at a character boundary, and the status output then swaps to the other buffer.

Back-pressure rule: the message write port and the arm port share one ready. Ready is low for as long as an armed message is waiting for its boundary. A write or arm completes only in a cycle where valid and ready are both high. Between those cycles the host must hold its data.

Top module: `bos_link_tx`

## Requirements
- R1: After reset, `tx_bit` is 1 (abort fill), `buf_next` is 0, `eot_flag` is 0, and both `wr_ready` and `arm_ready` are 1.
- R2: A write with `wr_valid` and `wr_ready` both high stores `wr_data` in the buffer named by `buf_next`. The host frames a message d5..d0 as the byte {0,d5,d4,d3,d2,d1,d0,0}.
- R3: A codeword is 16 bits: eight ones, then the stored byte, most significant bit first. `tx_bit` always shows the current bit. A clock edge with `bit_req` high consumes that bit and moves on to the next one.
- R4: When the count armed with the message is N (1 to 127), exactly N codewords are sent. `eot_flag` goes high in the cycle after the edge that consumed the last bit of the last codeword.
- R5: When the count armed with the message is 0, the codeword repeats without end and `eot_flag` is never set by it.
- R6: When no codeword is being sent, fill is sent in 8-bit characters. `fill_flag` is sampled at the start of each fill character: 1 gives 0x7E (most significant bit first), 0 gives eight ones.
- R7: `eot_flag` stays high until a cycle with `eot_clr` high clears it. If the flag is set and cleared in the same cycle, setting wins.
- R8: An accepted arm makes the message pending and captures the last value written through `cnt_we`/`cnt_data`. While a message is pending, `wr_ready` and `arm_ready` are low. A pending message starts at the next boundary that is not inside a finite run: the end of a fill character, the end of any codeword of an endless run, or the end of the last codeword of a finite run. It then follows without any fill in between.
- R9: `buf_next` toggles in the cycle after a pending message starts. The host may then write the other buffer while the current message is being sent, and the codeword on the line is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Message byte write valid |
| wr_data | input | 8 | Framed message byte |
| wr_ready | output | 1 | Message write may complete |
| cnt_we | input | 1 | Repetition count write strobe |
| cnt_data | input | 7 | Repetition count (0 = endless) |
| arm_valid | input | 1 | Arm request for the buffer named by `buf_next` |
| arm_ready | output | 1 | Arm may complete |
| fill_flag | input | 1 | Fill choice: 1 = idle flags, 0 = abort ones |
| buf_next | output | 1 | Buffer free for the next message |
| bit_req | input | 1 | Data-link bit request strobe |
| tx_bit | output | 1 | Current data-link bit |
| eot_flag | output | 1 | Sticky end-of-transfer interrupt |
| eot_clr | input | 1 | Clears `eot_flag` |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is setting and clearing the end-of-transfer flag. The second pair is a pending message waiting while a finite run reaches its final boundary. To provoke the first, the bench holds `eot_clr` high for the whole of a short finite run, so the setting edge meets an active clear. The flag must read high for exactly one cycle and then drop. To provoke the second, the bench arms a new message while a finite run is in progress. The new codeword must start right after the last repetition with no fill in between, and `eot_flag` must still be set. The bench checks both against a queue-based model of the bit stream, compared every cycle, while `bit_req` is sparse, dense, or high in every cycle.

// File: rtl/bos_pkg.sv
package bos_pkg;
  typedef enum logic {
    M_FILL = 1'b0,
    M_SEND = 1'b1
  } tx_mode_e;

  localparam logic [7:0] IDLE_FLAG = 8'h7E;
endpackage

// File: rtl/bos_msg_store.sv
module bos_msg_store #(
  parameter int MSG_W = 8,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [MSG_W-1:0] wr_data,
  output logic             wr_ready,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_data,
  input  logic             arm_valid,
  output logic             arm_ready,
  input  logic             take,
  output logic             pend,
  output logic [CNT_W-1:0] pend_cnt,
  output logic             next_buf,
  output logic [MSG_W-1:0] cur_byte
);
  localparam int NBUF = 2;

  logic [MSG_W-1:0] buf_q [NBUF];
  logic [CNT_W-1:0] cnt_q, pcnt_q;
  logic             pend_q, next_q, act_q;
  logic             wr_fire, arm_fire;

  assign wr_ready  = !pend_q;
  assign arm_ready = !pend_q;
  assign wr_fire   = wr_valid && wr_ready;
  assign arm_fire  = arm_valid && arm_ready;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n)                          buf_q[g] <= '0;
      else if (wr_fire && (next_q == g[0])) buf_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
      pend_q <= 1'b0;
      next_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (cnt_we) cnt_q <= cnt_data;
      if (arm_fire) begin
        pend_q <= 1'b1;
        pcnt_q <= cnt_q;
      end else if (take) begin
        pend_q <= 1'b0;
        act_q  <= next_q;
        next_q <= !next_q;
      end
    end
  end

  assign pend     = pend_q;
  assign pend_cnt = pcnt_q;
  assign next_buf = next_q;
  assign cur_byte = buf_q[act_q];

  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> ($stable(buf_q[0]) && $stable(buf_q[1]))); // R8
  AST_SWAP_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> (next_q != $past(next_q))); // R9
endmodule

// File: rtl/bos_seq.sv
module bos_seq
  import bos_pkg::*;
#(
  parameter int MSG_W    = 8,
  parameter int CNT_W    = 7,
  parameter int PRE_BITS = 8,
  parameter int FILL_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_req,
  input  logic             fill_flag,
  input  logic             eot_clr,
  input  logic             pend,
  input  logic [CNT_W-1:0] pend_cnt,
  input  logic [MSG_W-1:0] cur_byte,
  output logic             take,
  output logic             tx_bit,
  output logic             eot
);
  localparam int CW_BITS = PRE_BITS + MSG_W;
  localparam int PTR_W   = $clog2(CW_BITS);

  tx_mode_e         mode_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] rem_q;
  logic             inf_q, fk_q, eot_q;
  logic             last, boundary, fin, more, eot_set;
  logic [PTR_W-1:0] boff;
  logic [MSG_W-1:0] msg_sh;
  logic [7:0]       flag_sh;

  assign last     = (mode_q == M_SEND) ? (ptr_q == PTR_W'(CW_BITS - 1))
                                       : (ptr_q == PTR_W'(FILL_W - 1));
  assign boundary = bit_req && last;
  assign fin      = (mode_q == M_SEND) && !inf_q;
  assign more     = fin && (rem_q > CNT_W'(1));
  assign take     = boundary && !more && pend;
  assign eot_set  = boundary && fin && !more;

  always_comb begin
    boff    = ptr_q - PTR_W'(PRE_BITS);
    msg_sh  = cur_byte << boff;
    flag_sh = IDLE_FLAG << ptr_q;
    if (mode_q == M_SEND) tx_bit = (ptr_q < PTR_W'(PRE_BITS)) ? 1'b1 : msg_sh[MSG_W-1];
    else                  tx_bit = fk_q ? flag_sh[7] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_FILL;
      ptr_q  <= '0;
      rem_q  <= '0;
      inf_q  <= 1'b0;
      fk_q   <= 1'b0;
      eot_q  <= 1'b0;
    end else begin
      if (eot_set)      eot_q <= 1'b1;
      else if (eot_clr) eot_q <= 1'b0;
      if (bit_req) begin
        if (!last) begin
          ptr_q <= ptr_q + PTR_W'(1);
        end else begin
          ptr_q <= '0;
          if (more) begin
            rem_q <= rem_q - CNT_W'(1);
          end else if (pend) begin
            mode_q <= M_SEND;
            rem_q  <= pend_cnt;
            inf_q  <= (pend_cnt == '0);
          end else if (!((mode_q == M_SEND) && inf_q)) begin
            mode_q <= M_FILL;
            fk_q   <= fill_flag;
          end
        end
      end
    end
  end

  assign eot = eot_q;

  AST_TAKE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (bit_req && pend)); // R8
  AST_FILL_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FILL) |-> (ptr_q < PTR_W'(FILL_W))); // R6
  AST_EOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_q && !eot_clr) |=> eot_q); // R7
  AST_ENDLESS_NO_EOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_SEND) && inf_q) |=> !$rose(eot_q)); // R5
endmodule

// File: rtl/bos_link_tx.sv
module bos_link_tx #(
  parameter int MSG_W    = 8,
  parameter int CNT_W    = 7,
  parameter int PRE_BITS = 8,
  parameter int FILL_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [MSG_W-1:0] wr_data,
  output logic             wr_ready,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_data,
  input  logic             arm_valid,
  output logic             arm_ready,
  input  logic             fill_flag,
  output logic             buf_next,
  input  logic             bit_req,
  output logic             tx_bit,
  output logic             eot_flag,
  input  logic             eot_clr
);
  logic             take, pend;
  logic [CNT_W-1:0] pend_cnt;
  logic [MSG_W-1:0] cur_byte;

  bos_msg_store #(.MSG_W(MSG_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .cnt_we(cnt_we), .cnt_data(cnt_data),
    .arm_valid(arm_valid), .arm_ready(arm_ready),
    .take(take), .pend(pend), .pend_cnt(pend_cnt),
    .next_buf(buf_next), .cur_byte(cur_byte)
  );

  bos_seq #(.MSG_W(MSG_W), .CNT_W(CNT_W), .PRE_BITS(PRE_BITS), .FILL_W(FILL_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .bit_req(bit_req), .fill_flag(fill_flag), .eot_clr(eot_clr),
    .pend(pend), .pend_cnt(pend_cnt), .cur_byte(cur_byte),
    .take(take), .tx_bit(tx_bit), .eot(eot_flag)
  );

  AST_READY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready == arm_ready)); // R8
endmodule

// File: tb/bos_link_tx_bench.sv
`timescale 1ns/1ps
module bos_link_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, cnt_we = 1'b0, arm_valid = 1'b0;
  logic fill_flag = 1'b0, bit_req = 1'b0, eot_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [6:0] cnt_data = '0;
  logic wr_ready, arm_ready, buf_next, tx_bit, eot_flag;

  always #2.5 clk = ~clk;

  bos_link_tx u_bos_link_tx (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .cnt_we(cnt_we), .cnt_data(cnt_data),
    .arm_valid(arm_valid), .arm_ready(arm_ready), .fill_flag(fill_flag),
    .buf_next(buf_next), .bit_req(bit_req), .tx_bit(tx_bit),
    .eot_flag(eot_flag), .eot_clr(eot_clr)
  );

  int n_cmp = 0, n_bad = 0, req_pct = 70;
  // Reference model: a queue holds the bits of the current character
  bit   exp_q[$];
  bit   m_send, m_inf, m_eot, m_pend, m_next, m_act;
  int   m_rem, m_pcnt, m_cnt;
  bit [7:0] m_buf[2];

  task automatic push_char(input bit is_send, input bit flag);
    if (is_send) begin
      for (int i = 0; i < 8; i++) exp_q.push_back(1'b1);
      for (int i = 7; i >= 0; i--) exp_q.push_back(m_buf[m_act][i]);
    end else begin
      for (int i = 7; i >= 0; i--) exp_q.push_back(flag ? ((8'h7E >> i) & 1) : 1'b1);
    end
  endtask

  task automatic model_reset();
    exp_q.delete();
    m_send = 0; m_inf = 0; m_eot = 0; m_pend = 0; m_next = 0; m_act = 0;
    m_rem = 0; m_pcnt = 0; m_cnt = 0; m_buf[0] = 0; m_buf[1] = 0;
    push_char(1'b0, 1'b0);
  endtask

  task automatic model_step();
    bit rdy = !m_pend;
    bit eset = 0;
    if (wr_valid && rdy) m_buf[m_next] = wr_data;   // R2
    if (bit_req) begin
      void'(exp_q.pop_front());
      if (exp_q.size() == 0) begin
        if (m_send && !m_inf && m_rem > 1) begin
          m_rem--;
          push_char(1'b1, 1'b0);
        end else begin
          if (m_send && !m_inf) eset = 1;
          if (m_pend) begin
            m_pend = 0; m_act = m_next; m_next = !m_next;
            m_send = 1; m_rem = m_pcnt; m_inf = (m_pcnt == 0);
            push_char(1'b1, 1'b0);
          end else if (m_send && m_inf) begin
            push_char(1'b1, 1'b0);
          end else begin
            m_send = 0;
            push_char(1'b0, fill_flag);
          end
        end
      end
    end
    if (arm_valid && rdy) begin m_pend = 1; m_pcnt = m_cnt; end
    if (cnt_we) m_cnt = int'(cnt_data);
    if (eset) m_eot = 1; else if (eot_clr) m_eot = 0;
  endtask

  task automatic chk(input string tag, input string nm, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: %s got %0b expected %0b at %0t", tag, nm, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3", "tx_bit", tx_bit, exp_q[0]);
    chk("R4", "eot_flag", eot_flag, m_eot);
    chk("R9", "buf_next", buf_next, m_next);
    chk("R8", "wr_ready", wr_ready, !m_pend);
    chk("R8", "arm_ready", arm_ready, !m_pend);
  endtask

  // one clock: model consumes current inputs, then outputs compared at negedge
  task automatic tick();
    bit_req = ($urandom_range(99) < req_pct);
    model_step();
    @(negedge clk);
    compare_all();
    wr_valid = 0; arm_valid = 0; cnt_we = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic load_msg(input bit [7:0] b, input int cnt);
    while (m_pend) tick();
    cnt_we = 1; cnt_data = 7'(cnt); wr_valid = 1; wr_data = b;   // R2
    tick();
    arm_valid = 1;                                               // R8
    tick();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: state straight after reset
    chk("R1", "tx_bit", tx_bit, 1'b1);
    chk("R1", "buf_next", buf_next, 1'b0);
    chk("R1", "eot_flag", eot_flag, 1'b0);
    chk("R1", "wr_ready", wr_ready, 1'b1);
    chk("R1", "arm_ready", arm_ready, 1'b1);
    // R3 R4 R6: three repetitions of message 101011, then idle flags
    fill_flag = 1;
    load_msg(8'h56, 3);
    run(40);
    // R9: write and arm the other buffer while the first is on the line; R5 endless
    load_msg(8'h2A, 0);
    run(150);
    // R7: plain clear
    eot_clr = 1; tick(); eot_clr = 0;
    run(20);
    // R8: finite run of 2 pre-empts the endless run at a codeword boundary; abort fill after
    fill_flag = 0;
    eot_clr = 1;  // R7: clear held across the setting edge; set must win
    load_msg(8'h3C, 2);
    run(80);
    eot_clr = 0;
    // R8: next message waits through a finite run and follows it without fill
    req_pct = 100;
    load_msg(8'h66, 2);
    load_msg(8'h42, 1);
    run(60);
    // R6: flag fill with sparse requests, then count 127 boundary
    fill_flag = 1; req_pct = 25;
    run(60);
    req_pct = 90;
    load_msg(8'h7E, 127);
    run(2400);
    eot_clr = 1; tick(); eot_clr = 0;
    run(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule